// File: doc/BRIEF.md
# Pack Temperature Zone and Rise-Rate Gate

This block checks every pack temperature sample taken during a service discharge and returns one verdict for it. The verdict contains an action (full current, derate, strong derate, pause, abort or refuse-to-start), a reason code and a current-scaling class. The block sorts the temperature into one of five zones with asymmetric bands. Each boundary has a hysteresis margin so that a reading that sits on a boundary does not make the verdict toggle. The block also measures how far the temperature has climbed over a fixed window of samples. A climb that is too fast pauses the discharge, even in the normal zone. If fast climbs keep recurring, the block aborts and latches the abort.

After a pause, current may resume only once the temperature has stayed in a usable zone, with no fast climb, for a programmable number of consecutive samples. If the primary sensor reports a fault, the block takes the redundant reading when that reading is valid. If it is not, the block falls back to the strong-derate class. A fault is always reported as the reason. The thresholds sit in registers. They can be loaded only while no discharge is active, and loading them also re-arms the gate.

Samples enter on a valid/ready stream. `smp_ready` is high in every cycle except one in which an idle configuration load happens; in that cycle the sample is held off. Results are not back-pressured: `act_valid` pulses for one cycle, one clock after each accepted sample.

Top module: `thermal_gate`

## Requirements
- R1: Each sample accepted (`smp_valid && smp_ready`) gives exactly one result with `act_valid` high on the next clock. Without an accepted sample, `act_valid` stays low. `smp_ready` drops only in a cycle with `cfg_load` high and `active` low.
- R2: Zones for a temperature T (signed, integer units): T < cold is forbid; T < cool is cool; T < hot is normal; T <= abort_th is warm; above that is hot. The defaults are 0, 10, 45 and 55. The actions are cool → derate (1), normal → normal (0), warm → strong derate (2) and hot → abort (4) with reason zone (1). Normal carries reason none (0).
- R3: Hysteresis of h units. Moving to a higher zone uses the zone of T−h, but only if that zone is above the current zone. Moving to a lower zone uses the zone of T+h, but only if that zone is below the current zone. Otherwise the zone holds. The first sample after reset or a load takes its zone with no margin.
- R4: A sample is a rate violation when the window holds RATE_WIN earlier samples and T minus the sample RATE_WIN accepted strobes earlier exceeds the rate limit. A violation gives pause (3) with reason rate (2), in any zone.
- R5: Every violation increments a counter. When the incremented count reaches viol_max, the result is abort (4) with reason repeated-rate (3). The counter clears only when a dwell period completes.
- R6: A sample is safe when it is in the cool, normal or warm zone and is not a violation. Once paused, the output stays at pause (reason 2) until the sample that completes dwell_len consecutive safe samples. `resume_ok` is low while paused or aborted.
- R7: Any abort sets `abort_flag`. It holds through all later samples, each of which returns abort with the reason that was latched. Only an idle load clears it.
- R8: A forbid-zone sample returns refuse (5) with reason zone when `active` is low. When `active` is high it returns an abort with reason zone.
- R9: With `smp_fault` high and `red_ok` high, `red_temp` replaces the primary sample in every check. A non-pause, non-abort result then carries reason sensor (4).
- R10: With `smp_fault` high and `red_ok` low, the result is strong derate (2) with reason sensor (4). That sample neither enters the rate window nor moves the zone.
- R11: `cfg_load` with `active` low loads all thresholds and clears the zone, the window, the counters, the pause and the abort. With `active` high it has no effect.
- R12: `scale` is 3 for normal, 2 for derate, 1 for strong derate, and 0 for pause, abort and refuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active | input | 1 | A discharge is running |
| cfg_load | input | 1 | Load thresholds (honoured only when idle) |
| cfg_cold | input | TW | Lower edge of the cool zone |
| cfg_cool | input | TW | Lower edge of the normal zone |
| cfg_hot | input | TW | Lower edge of the warm zone |
| cfg_abort | input | TW | Upper edge of the warm zone |
| cfg_hyst | input | TW | Hysteresis margin |
| cfg_rate | input | TW | Largest allowed rise per window |
| cfg_viol_max | input | CW | Violation count that aborts |
| cfg_dwell | input | CW | Safe samples needed to end a pause |
| smp_valid | input | 1 | Sample strobe |
| smp_ready | output | 1 | Sample accepted this cycle |
| smp_temp | input | TW | Primary temperature, signed |
| smp_fault | input | 1 | Primary sensor fault |
| red_temp | input | TW | Redundant temperature, signed |
| red_ok | input | 1 | Redundant reading usable |
| act_valid | output | 1 | Result strobe |
| action | output | 3 | Action code |
| reason | output | 3 | Reason code |
| scale | output | 2 | Current scaling class |
| resume_ok | output | 1 | Not paused and not aborted |
| abort_flag | output | 1 | Latched abort |

## Verification
The bench walks the temperature one unit at a time up through every boundary and back down again. A design without hysteresis would change zone at the raw boundary, two samples too early. The bench steps the temperature exactly past the rate limit inside the normal zone. A design that compared against the wrong window slot would miss the pause, or would pause on a slow ramp. It runs repeated jumps to reach the abort count, and a pause followed by a decline to count the dwell. An off-by-one in either count moves the abort or the resume by one sample. It also covers faulted samples with and without a redundant reading, loads attempted during an active discharge, and a long pseudo-random walk. If the design let the blind fallback enter the rate window, or honoured a load while active, the later verdicts would diverge from the bench's model.

// File: rtl/thermal_gate_pkg.sv
package thermal_gate_pkg;
  typedef enum logic [2:0] {
    Z_FORBID = 3'd0, Z_COOL = 3'd1, Z_NORM = 3'd2, Z_WARM = 3'd3, Z_HOT = 3'd4
  } zone_e;

  typedef enum logic [2:0] {
    A_NORMAL = 3'd0, A_DERATE = 3'd1, A_STRONG = 3'd2,
    A_PAUSE  = 3'd3, A_ABORT  = 3'd4, A_REFUSE = 3'd5
  } act_e;

  typedef enum logic [2:0] {
    RS_NONE = 3'd0, RS_ZONE = 3'd1, RS_RATE = 3'd2,
    RS_RATE_REPEAT = 3'd3, RS_SENSOR = 3'd4
  } rsn_e;
endpackage

// File: rtl/thermal_zone_track.sv
module thermal_zone_track
  import thermal_gate_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd,
  input  logic signed [W-1:0] t,
  input  logic signed [W-1:0] th_cold,
  input  logic signed [W-1:0] th_cool,
  input  logic signed [W-1:0] th_hot,
  input  logic signed [W-1:0] th_abort,
  input  logic signed [W-1:0] hyst,
  output zone_e               zone_nx
);
  zone_e zq;
  logic  have;

  function automatic zone_e classify(input logic signed [W:0] v,
                                     input logic signed [W:0] c0, c1, c2, c3);
    if (v < c0)       return Z_FORBID;
    else if (v < c1)  return Z_COOL;
    else if (v < c2)  return Z_NORM;
    else if (v <= c3) return Z_WARM;
    else              return Z_HOT;
  endfunction

  logic signed [W:0] tx, hx, c0, c1, c2, c3;
  zone_e raw, lo_side, hi_side;

  always_comb begin
    tx = {t[W-1], t};
    hx = {hyst[W-1], hyst};
    c0 = {th_cold[W-1], th_cold};
    c1 = {th_cool[W-1], th_cool};
    c2 = {th_hot[W-1], th_hot};
    c3 = {th_abort[W-1], th_abort};
    raw     = classify(tx, c0, c1, c2, c3);
    lo_side = classify(tx - hx, c0, c1, c2, c3);
    hi_side = classify(tx + hx, c0, c1, c2, c3);
    if (!have)          zone_nx = raw;
    else if (raw > zq)  zone_nx = (lo_side > zq) ? lo_side : zq;
    else if (raw < zq)  zone_nx = (hi_side < zq) ? hi_side : zq;
    else                zone_nx = zq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zq   <= Z_NORM;
      have <= 1'b0;
    end else if (clr) begin
      zq   <= Z_NORM;
      have <= 1'b0;
    end else if (upd) begin
      zq   <= zone_nx;
      have <= 1'b1;
    end
  end
endmodule

// File: rtl/thermal_rate_window.sv
module thermal_rate_window #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd,
  input  logic signed [W-1:0] t,
  input  logic signed [W-1:0] lim,
  output logic                viol
);
  localparam int FW = $clog2(DEPTH + 1);

  logic signed [W-1:0] hist [DEPTH];
  logic [FW-1:0]       fill;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   hist[i] <= '0;
          else if (clr) hist[i] <= '0;
          else if (upd) hist[i] <= t;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   hist[i] <= '0;
          else if (clr) hist[i] <= '0;
          else if (upd) hist[i] <= hist[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                fill <= '0;
    else if (clr)                              fill <= '0;
    else if (upd && fill != FW'(DEPTH))        fill <= fill + 1'b1;
  end

  logic signed [W:0] rise, limx;
  always_comb begin
    rise = {t[W-1], t} - {hist[DEPTH-1][W-1], hist[DEPTH-1]};
    limx = {lim[W-1], lim};
    viol = (fill == FW'(DEPTH)) && (rise > limx);
  end
endmodule

// File: rtl/thermal_gate_seq.sv
module thermal_gate_seq
  import thermal_gate_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          accept,
  input  zone_e         zone,
  input  logic          viol,
  input  logic          fault,
  input  logic          active,
  input  logic [CW-1:0] viol_max,
  input  logic [CW-1:0] dwell_len,
  output logic          res_valid,
  output act_e          res_act,
  output rsn_e          res_rsn,
  output logic [1:0]    res_scale,
  output logic          paused_q,
  output logic          abort_q
);
  rsn_e          abort_rsn_q;
  logic [CW-1:0] vcnt, dwell;
  act_e          nx_act;
  rsn_e          nx_rsn;
  logic          set_abort, safe, done;
  logic [CW:0]   vinc;
  logic [1:0]    nx_scale;

  always_comb begin
    safe      = (zone == Z_COOL || zone == Z_NORM || zone == Z_WARM) && !viol;
    done      = safe && ({1'b0, dwell} + 1'b1 >= {1'b0, dwell_len});
    vinc      = {1'b0, vcnt} + 1'b1;
    set_abort = 1'b0;
    nx_act    = A_NORMAL;
    nx_rsn    = RS_NONE;
    if (abort_q) begin
      nx_act = A_ABORT;  nx_rsn = abort_rsn_q;
    end else if (zone == Z_HOT) begin
      nx_act = A_ABORT;  nx_rsn = RS_ZONE;  set_abort = 1'b1;
    end else if (viol && vinc >= {1'b0, viol_max}) begin
      nx_act = A_ABORT;  nx_rsn = RS_RATE_REPEAT;  set_abort = 1'b1;
    end else if (zone == Z_FORBID) begin
      nx_rsn = RS_ZONE;
      if (active) begin nx_act = A_ABORT; set_abort = 1'b1; end
      else        nx_act = A_REFUSE;
    end else if (viol || (paused_q && !done)) begin
      nx_act = A_PAUSE;  nx_rsn = RS_RATE;
    end else begin
      unique case (zone)
        Z_COOL:  nx_act = A_DERATE;
        Z_NORM:  nx_act = A_NORMAL;
        default: nx_act = A_STRONG;
      endcase
      if (fault)               nx_rsn = RS_SENSOR;
      else if (zone != Z_NORM) nx_rsn = RS_ZONE;
    end
    unique case (nx_act)
      A_NORMAL: nx_scale = 2'd3;
      A_DERATE: nx_scale = 2'd2;
      A_STRONG: nx_scale = 2'd1;
      default:  nx_scale = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;  res_act <= A_NORMAL;  res_rsn <= RS_NONE;  res_scale <= 2'd0;
      paused_q  <= 1'b0;  abort_q <= 1'b0;      abort_rsn_q <= RS_NONE;
      vcnt      <= '0;    dwell   <= '0;
    end else if (clr) begin
      res_valid <= 1'b0;
      paused_q  <= 1'b0;  abort_q <= 1'b0;      abort_rsn_q <= RS_NONE;
      vcnt      <= '0;    dwell   <= '0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_act   <= nx_act;
        res_rsn   <= nx_rsn;
        res_scale <= nx_scale;
        if (!abort_q) begin
          if (viol || !safe)       dwell <= '0;
          else if (dwell < dwell_len) dwell <= dwell + 1'b1;
          if (viol)                vcnt <= vinc[CW-1:0];
          else if (done)           vcnt <= '0;
          if (viol)                paused_q <= 1'b1;
          else if (done)           paused_q <= 1'b0;
          if (set_abort) begin
            abort_q     <= 1'b1;
            abort_rsn_q <= nx_rsn;
          end
        end
      end
    end
  end
endmodule

// File: rtl/thermal_gate.sv
module thermal_gate
  import thermal_gate_pkg::*;
#(
  parameter int TW        = 10,
  parameter int RATE_WIN  = 4,
  parameter int CW        = 8,
  parameter int DEF_COLD  = 0,
  parameter int DEF_COOL  = 10,
  parameter int DEF_HOT   = 45,
  parameter int DEF_ABORT = 55,
  parameter int DEF_HYST  = 2,
  parameter int DEF_RATE  = 6,
  parameter int DEF_VMAX  = 3,
  parameter int DEF_DWELL = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic                 cfg_load,
  input  logic signed [TW-1:0] cfg_cold,
  input  logic signed [TW-1:0] cfg_cool,
  input  logic signed [TW-1:0] cfg_hot,
  input  logic signed [TW-1:0] cfg_abort,
  input  logic signed [TW-1:0] cfg_hyst,
  input  logic signed [TW-1:0] cfg_rate,
  input  logic [CW-1:0]        cfg_viol_max,
  input  logic [CW-1:0]        cfg_dwell,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic signed [TW-1:0] smp_temp,
  input  logic                 smp_fault,
  input  logic signed [TW-1:0] red_temp,
  input  logic                 red_ok,
  output logic                 act_valid,
  output logic [2:0]           action,
  output logic [2:0]           reason,
  output logic [1:0]           scale,
  output logic                 resume_ok,
  output logic                 abort_flag
);
  logic signed [TW-1:0] th_cold, th_cool, th_hot, th_abort, th_hyst, th_rate;
  logic [CW-1:0]        th_vmax, th_dwell;
  logic                 ld, accept, blind, upd, viol_raw, viol, paused_q, abort_q;
  logic signed [TW-1:0] tsel;
  zone_e                zone_nx, zone_eff;
  act_e                 res_act;
  rsn_e                 res_rsn;

  assign ld        = cfg_load && !active;
  assign smp_ready = !ld;
  assign accept    = smp_valid && smp_ready;
  assign blind     = smp_fault && !red_ok;
  assign tsel      = (smp_fault && red_ok) ? red_temp : smp_temp;
  assign upd       = accept && !blind;
  assign zone_eff  = blind ? Z_WARM : zone_nx;
  assign viol      = viol_raw && !blind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_cold  <= TW'(DEF_COLD);   th_cool <= TW'(DEF_COOL);
      th_hot   <= TW'(DEF_HOT);    th_abort <= TW'(DEF_ABORT);
      th_hyst  <= TW'(DEF_HYST);   th_rate <= TW'(DEF_RATE);
      th_vmax  <= CW'(DEF_VMAX);   th_dwell <= CW'(DEF_DWELL);
    end else if (ld) begin
      th_cold  <= cfg_cold;        th_cool <= cfg_cool;
      th_hot   <= cfg_hot;         th_abort <= cfg_abort;
      th_hyst  <= cfg_hyst;        th_rate <= cfg_rate;
      th_vmax  <= cfg_viol_max;    th_dwell <= cfg_dwell;
    end
  end

  thermal_zone_track #(.W(TW)) u_zone (
    .clk(clk), .rst_n(rst_n), .clr(ld), .upd(upd), .t(tsel),
    .th_cold(th_cold), .th_cool(th_cool), .th_hot(th_hot), .th_abort(th_abort),
    .hyst(th_hyst), .zone_nx(zone_nx)
  );

  thermal_rate_window #(.W(TW), .DEPTH(RATE_WIN)) u_rate (
    .clk(clk), .rst_n(rst_n), .clr(ld), .upd(upd), .t(tsel),
    .lim(th_rate), .viol(viol_raw)
  );

  thermal_gate_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(ld), .accept(accept), .zone(zone_eff),
    .viol(viol), .fault(smp_fault), .active(active),
    .viol_max(th_vmax), .dwell_len(th_dwell),
    .res_valid(act_valid), .res_act(res_act), .res_rsn(res_rsn), .res_scale(scale),
    .paused_q(paused_q), .abort_q(abort_q)
  );

  assign action     = res_act;
  assign reason     = res_rsn;
  assign abort_flag = abort_q;
  assign resume_ok  = !paused_q && !abort_q;
endmodule

// File: rtl/thermal_gate_chk.sv
module thermal_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       active,
  input logic       cfg_load,
  input logic       smp_valid,
  input logic       smp_ready,
  input logic       act_valid,
  input logic [2:0] action,
  input logic [2:0] reason,
  input logic       resume_ok,
  input logic       abort_flag
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> act_valid);                              // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && smp_ready) |=> !act_valid);                            // R1
  AST_PAUSE_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && action == 3'd3) |-> (reason == 3'd2 && !resume_ok));   // R4
  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_flag && !(cfg_load && !active)) |=> abort_flag);               // R7
  AST_ABORT_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && abort_flag) |-> action == 3'd4);                        // R7
  AST_REFUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && action == 3'd5) |-> !$past(active));                    // R8
endmodule

bind thermal_gate thermal_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .cfg_load(cfg_load),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .act_valid(act_valid),
  .action(action), .reason(reason), .resume_ok(resume_ok), .abort_flag(abort_flag)
);

// File: tb/thermal_gate_bench.sv
`timescale 1ns/1ps
module thermal_gate_bench;
  localparam int TW = 10;
  localparam int CW = 8;
  localparam int RW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, active = 1'b0, cfg_load = 1'b0;
  logic signed [TW-1:0] cfg_cold = '0, cfg_cool = '0, cfg_hot = '0, cfg_abort = '0;
  logic signed [TW-1:0] cfg_hyst = '0, cfg_rate = '0;
  logic [CW-1:0] cfg_viol_max = '0, cfg_dwell = '0;
  logic smp_valid = 1'b0, smp_fault = 1'b0, red_ok = 1'b0;
  logic signed [TW-1:0] smp_temp = '0, red_temp = '0;
  logic smp_ready, act_valid, resume_ok, abort_flag;
  logic [2:0] action, reason;
  logic [1:0] scale;

  thermal_gate #(.TW(TW), .RATE_WIN(RW), .CW(CW)) u_thermal_gate (.*);

  int n_chk = 0, n_bad = 0;
  string tag = "R2";

  int c_cold = 0, c_cool = 10, c_hot = 45, c_abt = 55, c_hys = 2, c_rate = 6;
  int c_vmax = 3, c_dwell = 5;
  int m_z = 2, m_have = 0, m_fill = 0, m_ab = 0, m_abr = 0, m_pau = 0, m_vc = 0, m_dw = 0;
  int m_hist [RW];

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int cls(int v);
    if (v < c_cold) return 0;
    if (v < c_cool) return 1;
    if (v < c_hot)  return 2;
    if (v <= c_abt) return 3;
    return 4;
  endfunction

  task automatic model_clear();
    m_z = 2; m_have = 0; m_fill = 0; m_ab = 0; m_abr = 0;
    m_pau = 0; m_vc = 0; m_dw = 0;
    for (int i = 0; i < RW; i++) m_hist[i] = 0;
  endtask

  task automatic model(input int t, input bit flt, input int rt, input bit rok,
                       output int ea, output int er, output int es);
    bit blind, viol, safe, done, setab;
    int ts, raw, up, dn, nz, z, vinc;
    blind = flt && !rok;
    ts    = (flt && rok) ? rt : t;
    raw = cls(ts); up = cls(ts - c_hys); dn = cls(ts + c_hys);
    if (!m_have)       nz = raw;
    else if (raw > m_z) nz = (up > m_z) ? up : m_z;
    else if (raw < m_z) nz = (dn < m_z) ? dn : m_z;
    else               nz = m_z;
    z    = blind ? 3 : nz;
    viol = !blind && m_fill == RW && (ts - m_hist[RW-1]) > c_rate;
    if (!blind) begin
      m_z = nz; m_have = 1;
      for (int i = RW - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = ts;
      if (m_fill < RW) m_fill++;
    end
    safe  = (z >= 1 && z <= 3) && !viol;
    done  = safe && (m_dw + 1 >= c_dwell);
    vinc  = m_vc + 1;
    setab = 0;
    if (m_ab != 0)                     begin ea = 4; er = m_abr; end
    else if (z == 4)                   begin ea = 4; er = 1; setab = 1; end
    else if (viol && vinc >= c_vmax)   begin ea = 4; er = 3; setab = 1; end
    else if (z == 0) begin
      er = 1;
      if (active) begin ea = 4; setab = 1; end else ea = 5;
    end
    else if (viol || (m_pau != 0 && !done)) begin ea = 3; er = 2; end
    else begin
      ea = (z == 1) ? 1 : (z == 2) ? 0 : 2;
      er = flt ? 4 : (z == 2 ? 0 : 1);
    end
    es = (ea == 0) ? 3 : (ea == 1) ? 2 : (ea == 2) ? 1 : 0;
    if (m_ab == 0) begin
      if (viol || !safe) m_dw = 0; else if (m_dw < c_dwell) m_dw++;
      if (viol) m_vc = vinc; else if (done) m_vc = 0;
      if (viol) m_pau = 1; else if (done) m_pau = 0;
      if (setab) begin m_ab = 1; m_abr = er; end
    end
  endtask

  task automatic send(int t, bit flt = 0, int rt = 0, bit rok = 0);
    int ea, er, es;
    model(t, flt, rt, rok, ea, er, es);
    @(negedge clk);
    smp_valid = 1'b1; smp_temp = TW'(t); smp_fault = flt; red_temp = TW'(rt); red_ok = rok;
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R1", int'(act_valid), 1);
    chk(tag, int'(action), ea);
    chk(tag, int'(reason), er);
    chk("R12", int'(scale), es);
    chk("R7", int'(abort_flag), m_ab);
    chk("R6", int'(resume_ok), (m_pau == 0 && m_ab == 0) ? 1 : 0);
  endtask

  task automatic load(int lc, int lo, int hi, int ab, int hy, int rt, int vm, int dw);
    @(negedge clk);
    cfg_load = 1'b1;
    cfg_cold = TW'(lc); cfg_cool = TW'(lo); cfg_hot = TW'(hi); cfg_abort = TW'(ab);
    cfg_hyst = TW'(hy); cfg_rate = TW'(rt); cfg_viol_max = CW'(vm); cfg_dwell = CW'(dw);
    #1 chk("R1", int'(smp_ready), active ? 1 : 0);
    if (!active) begin
      c_cold = lc; c_cool = lo; c_hot = hi; c_abt = ab; c_hys = hy; c_rate = rt;
      c_vmax = vm; c_dwell = dw;
      model_clear();
    end
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic set_active(bit b);
    @(negedge clk);
    active = b;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lf, t;
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1", int'(act_valid), 0);
    chk("R7", int'(abort_flag), 0);
    chk("R6", int'(resume_ok), 1);
    chk("R1", int'(smp_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(act_valid), 0);

    // R2 / R3 / R8: idle sweep up then down through every boundary
    tag = "R3";
    for (int v = -10; v <= 54; v++) send(v);
    for (int v = 54; v >= -10; v--) send(v);
    @(negedge clk);
    chk("R1", int'(act_valid), 0);

    // R2: hot zone aborts even when idle, then a load clears it
    tag = "R2";
    for (int v = 50; v <= 58; v++) send(v);
    send(20);
    load(0, 10, 45, 55, 2, 6, 3, 5);
    chk("R11", int'(abort_flag), 0);

    // R11: load during an active discharge has no effect
    set_active(1);
    load(-50, 40, 42, 44, 0, 1, 1, 1);
    tag = "R11";
    for (int k = 0; k < 6; k++) send(25);

    // R4 / R6: one fast rise, then a slow decline through the dwell
    tag = "R4";
    send(32);
    tag = "R6";
    for (int k = 0; k < 8; k++) send(26);

    // R5: repeated fast rises escalate to abort
    tag = "R5";
    send(34); send(34); send(42); send(42);
    tag = "R7";
    for (int k = 0; k < 3; k++) send(25);
    load(0, 10, 45, 55, 2, 6, 3, 5);
    chk("R11", int'(abort_flag), 1);

    // R8: forbid while active aborts; forbid while idle refuses
    set_active(0);
    load(0, 10, 45, 55, 2, 6, 3, 5);
    set_active(1);
    tag = "R8";
    send(-4); send(20);
    set_active(0);
    load(0, 10, 45, 55, 2, 6, 3, 5);
    send(-4);

    // R9 / R10: sensor fault handling
    set_active(1);
    tag = "R9";
    send(100, 1, 30, 1); send(100, 1, 31, 1); send(200, 1, 50, 1);
    send(30, 1, 30, 1);
    tag = "R10";
    send(30, 1, 0, 0); send(-60, 1, 0, 0); send(90, 1, 0, 0);
    send(31);

    // Pseudo-random walk with faults, mode changes and reloads
    set_active(0);
    load(0, 10, 45, 55, 2, 6, 4, 3);
    tag = "R4";
    lf = 16'hACE1;
    t = 20;
    for (int k = 0; k < 600; k++) begin
      lf = ((lf >> 1) | (((lf ^ (lf >> 2) ^ (lf >> 3) ^ (lf >> 5)) & 1) << 15)) & 16'hFFFF;
      t = t + (lf % 7) - 3;
      if ((lf & 31) == 7) t = t + 9;
      if (t < -15) t = -15;
      if (t > 62) t = 40;
      if (k % 50 == 0) begin
        set_active(0);
        load(0, 10, 45, 55, 2, 6, 4, 3);
        set_active(((k / 50) % 3) != 0);
      end
      if (k % 29 == 5) send(t, 1, t + 1, (lf & 2) != 0);
      else             send(t);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule